// File: doc/BRIEF.md
# Egress Fragment Scheduler

This block decides which logical port is served next on one egress port, then moves that port's next buffered fragment out word by word. A table of descriptors, one for each logical identifier (LID), says whether that LID is bound to this egress port and which logical-port (LP) address it carries. Three conditions must hold in the same cycle for a LID to be a candidate. It must be bound. The buffer must flag that it holds a complete fragment for that LID. The downstream status of its LP must allow transfer.

Candidates are served in round-robin order. Once a fragment is granted, it is read from the fragment buffer on consecutive cycles until it ends. It ends after the configured fragment length, or earlier at an end-of-packet word, because a packet's last fragment may be short. Each word is forwarded with its start-of-packet, end-of-packet and error markers. The LP address is sent on the egress side only when the served LP changes.

Top module: `eg_frag_sched`

## Requirements
- R1: After reset, `rd_en_o`, `eg_vld_o`, `eg_fend_o` and `eg_addr_vld_o` are low and every table entry is unbound.
- R2: A write with `tbl_wr_en` high stores `tbl_wr_bind` and `tbl_wr_lp` into entry `tbl_wr_idx` at the clock edge. A LID whose entry is unbound is never granted.
- R3: A LID is eligible only when it is bound, its `frag_rdy_i` bit is high, and the 2-bit status of its LP is 00 (starving) or 01 (hungry). Code 10 (satisfied) and code 11 (reserved) block it. Whenever the block is idle and some LID is eligible, a grant happens in that cycle.
- R4: The grant goes to the first eligible LID found by searching upward from one past the last granted LID, wrapping at the table size. After reset the search starts at LID 0.
- R5: A granted fragment is read on consecutive cycles with `rd_lid_o` held constant. Status or readiness changes during the fragment neither stop it nor start another grant.
- R6: A fragment ends after FRAG_LEN words, or at the first word presented with `buf_eop_i` high, whichever comes first. `eg_fend_o` marks its last output word.
- R7: Each word read is presented on the egress outputs one cycle later: `eg_vld_o` follows `rd_en_o`, and data, SOP, EOP and error follow the buffer inputs.
- R8: `eg_addr_vld_o` pulses only on the first word of a fragment, and only when its LP differs from the LP of the previous fragment or when it is the first fragment since reset. `eg_addr_o` then equals the LP stored for the granted LID.
- R9: At least one idle (arbitration) cycle separates the last read of one fragment from the first read of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Descriptor table write strobe |
| tbl_wr_idx | input | IDX_W | LID whose descriptor is written |
| tbl_wr_bind | input | 1 | 1 binds the LID to this egress port |
| tbl_wr_lp | input | LP_W | LP address carried by the LID |
| lp_stat_i | input | 2*NUM_LP | Per-LP status: 00 starving, 01 hungry, 10 satisfied, 11 reserved |
| frag_rdy_i | input | N_ENT | Per-LID complete-fragment-buffered flag |
| rd_en_o | output | 1 | Fragment buffer read, one word per cycle |
| rd_lid_o | output | IDX_W | LID being read |
| buf_data_i | input | DW | Word returned by the buffer in the read cycle |
| buf_sop_i | input | 1 | Word is start of packet |
| buf_eop_i | input | 1 | Word is end of packet |
| buf_err_i | input | 1 | Packet error marker |
| eg_vld_o | output | 1 | Egress word valid |
| eg_data_o | output | DW | Egress word |
| eg_sop_o | output | 1 | Egress start of packet |
| eg_eop_o | output | 1 | Egress end of packet |
| eg_err_o | output | 1 | Egress error marker |
| eg_fend_o | output | 1 | Last word of the fragment |
| eg_addr_vld_o | output | 1 | LP address is emitted with this word |
| eg_addr_o | output | LP_W | LP address |

## Verification
The grant is decided combinationally in the idle cycle, so the first read appears on `rd_lid_o` on the next edge. The bench samples at the falling edge and compares that read against the round-robin pick it computed from the inputs it held in the previous cycle. Egress words trail their reads by one register, so each output word is compared one cycle after the matching read. Fragment length, packet position, SOP/EOP, error and address expectations are fixed when the fragment's first read is seen. Reads are counted to confirm the fragment stops exactly at the expected length and that an idle cycle follows.

// File: rtl/eg_sched_pkg.sv
package eg_sched_pkg;

  // Per-LP downstream status code
  typedef enum logic [1:0] {
    LPS_STARVING  = 2'b00,
    LPS_HUNGRY    = 2'b01,
    LPS_SATISFIED = 2'b10,
    LPS_RESERVED  = 2'b11
  } lp_stat_e;

  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_MOVE = 1'b1
  } xf_state_e;

  // Starving and hungry allow transfer; satisfied and reserved block it
  function automatic logic lp_may_send(input logic [1:0] code);
    return (lp_stat_e'(code) == LPS_STARVING) || (lp_stat_e'(code) == LPS_HUNGRY);
  endfunction

  // The current word closes the fragment at packet end or at the length limit
  function automatic logic frag_done(input int unsigned cnt, input int unsigned lim,
                                     input logic eop);
    return eop || ((cnt + 1) >= lim);
  endfunction

endpackage

// File: rtl/eg_desc_table.sv
module eg_desc_table #(
  parameter int N_ENT = 64,
  parameter int LP_W  = 6,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic                        wr_bind_i,
  input  logic [LP_W-1:0]             wr_lp_i,
  output logic [N_ENT-1:0]            bind_o,
  output logic [N_ENT-1:0][LP_W-1:0]  lp_o
);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bind_o[g] <= 1'b0;
        lp_o[g]   <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        bind_o[g] <= wr_bind_i;
        lp_o[g]   <= wr_lp_i;
      end
    end
  end

  // R2: a write lands in the addressed entry
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (bind_o[$past(wr_idx_i)] == $past(wr_bind_i)) &&
                (lp_o[$past(wr_idx_i)] == $past(wr_lp_i)));

endmodule

// File: rtl/eg_rr_pick.sv
module eg_rr_pick #(
  parameter int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             found_o,
  output logic [IDX_W-1:0] pick_o
);

  // base + off modulo N_ENT, with base < N_ENT and off <= N_ENT
  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] base,
                                                input int unsigned off);
    int unsigned s;
    s = int'(base) + off;
    if (s >= N_ENT) s = s - N_ENT;
    return IDX_W'(s);
  endfunction

  logic [IDX_W-1:0] probe;

  // Scan from farthest to nearest so the nearest hit past last_i wins
  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    probe   = '0;
    for (int off = N_ENT; off >= 1; off--) begin
      probe = wrap_add(last_i, off);
      if (req_i[probe]) begin
        found_o = 1'b1;
        pick_o  = probe;
      end
    end
  end

endmodule

// File: rtl/eg_xfer_ctl.sv
module eg_xfer_ctl
  import eg_sched_pkg::*;
#(
  parameter int N_ENT    = 64,
  parameter int LP_W     = 6,
  parameter int FRAG_LEN = 16,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int CNT_W = $clog2(FRAG_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] lid_i,
  input  logic [LP_W-1:0]  lp_i,
  input  logic             new_addr_i,
  input  logic             eop_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] lid_o,
  output logic [LP_W-1:0]  lp_o,
  output logic             first_o,
  output logic             last_o,
  output logic             addr_pend_o
);

  xf_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (state_q == XF_MOVE);
  assign last_o = busy_o && frag_done(int'(cnt_q), FRAG_LEN, eop_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= XF_IDLE;
      cnt_q       <= '0;
      lid_o       <= '0;
      lp_o        <= '0;
      first_o     <= 1'b0;
      addr_pend_o <= 1'b0;
    end else if (start_i) begin
      state_q     <= XF_MOVE;
      cnt_q       <= '0;
      lid_o       <= lid_i;
      lp_o        <= lp_i;
      first_o     <= 1'b1;
      addr_pend_o <= new_addr_i;
    end else if (busy_o) begin
      first_o <= 1'b0;
      if (last_o) state_q <= XF_IDLE;
      else        cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  // R5: no new grant while a fragment is moving
  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);

  // R5: read LID holds until the fragment closes
  p_lid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |=> busy_o && $stable(lid_o));

  // R6: word counter never reaches the fragment length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (int'(cnt_q) < FRAG_LEN));

  // R9: an idle cycle follows every fragment
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !busy_o);

endmodule

// File: rtl/eg_frag_sched.sv
module eg_frag_sched
  import eg_sched_pkg::*;
#(
  parameter int N_ENT    = 64,
  parameter int LP_W     = 6,
  parameter int DW       = 32,
  parameter int FRAG_LEN = 16,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int NUM_LP = 1 << LP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tbl_wr_en,
  input  logic [IDX_W-1:0]            tbl_wr_idx,
  input  logic                        tbl_wr_bind,
  input  logic [LP_W-1:0]             tbl_wr_lp,
  input  logic [NUM_LP-1:0][1:0]      lp_stat_i,
  input  logic [N_ENT-1:0]            frag_rdy_i,
  output logic                        rd_en_o,
  output logic [IDX_W-1:0]            rd_lid_o,
  input  logic [DW-1:0]               buf_data_i,
  input  logic                        buf_sop_i,
  input  logic                        buf_eop_i,
  input  logic                        buf_err_i,
  output logic                        eg_vld_o,
  output logic [DW-1:0]               eg_data_o,
  output logic                        eg_sop_o,
  output logic                        eg_eop_o,
  output logic                        eg_err_o,
  output logic                        eg_fend_o,
  output logic                        eg_addr_vld_o,
  output logic [LP_W-1:0]             eg_addr_o
);

  logic [N_ENT-1:0]           tbl_bind;
  logic [N_ENT-1:0][LP_W-1:0] tbl_lp;
  logic [N_ENT-1:0]           elig;
  logic [IDX_W-1:0]           last_q, pick;
  logic                       found, busy, start, new_addr;
  logic [LP_W-1:0]            prev_lp_q, cur_lp;
  logic                       prev_vld_q, first_w, last_w, addr_pend, eg_first_q;

  eg_desc_table #(.N_ENT(N_ENT), .LP_W(LP_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(tbl_wr_en), .wr_idx_i(tbl_wr_idx),
    .wr_bind_i(tbl_wr_bind), .wr_lp_i(tbl_wr_lp),
    .bind_o(tbl_bind), .lp_o(tbl_lp)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_elig
    assign elig[g] = tbl_bind[g] & frag_rdy_i[g] & lp_may_send(lp_stat_i[tbl_lp[g]]);
  end

  eg_rr_pick #(.N_ENT(N_ENT)) u_pick (
    .req_i(elig), .last_i(last_q), .found_o(found), .pick_o(pick)
  );

  assign start    = !busy && found;
  assign new_addr = !prev_vld_q || (prev_lp_q != tbl_lp[pick]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= IDX_W'(N_ENT - 1);
      prev_lp_q  <= '0;
      prev_vld_q <= 1'b0;
    end else if (start) begin
      last_q     <= pick;
      prev_lp_q  <= tbl_lp[pick];
      prev_vld_q <= 1'b1;
    end
  end

  eg_xfer_ctl #(.N_ENT(N_ENT), .LP_W(LP_W), .FRAG_LEN(FRAG_LEN)) u_xf (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .lid_i(pick), .lp_i(tbl_lp[pick]), .new_addr_i(new_addr),
    .eop_i(buf_eop_i),
    .busy_o(busy), .lid_o(rd_lid_o), .lp_o(cur_lp),
    .first_o(first_w), .last_o(last_w), .addr_pend_o(addr_pend)
  );

  assign rd_en_o = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eg_vld_o      <= 1'b0;
      eg_data_o     <= '0;
      eg_sop_o      <= 1'b0;
      eg_eop_o      <= 1'b0;
      eg_err_o      <= 1'b0;
      eg_fend_o     <= 1'b0;
      eg_addr_vld_o <= 1'b0;
      eg_addr_o     <= '0;
      eg_first_q    <= 1'b0;
    end else begin
      eg_vld_o      <= busy;
      eg_data_o     <= busy ? buf_data_i : '0;
      eg_sop_o      <= busy & buf_sop_i;
      eg_eop_o      <= busy & buf_eop_i;
      eg_err_o      <= busy & buf_err_i;
      eg_fend_o     <= last_w;
      eg_addr_vld_o <= busy & first_w & addr_pend;
      eg_addr_o     <= cur_lp;
      eg_first_q    <= busy & first_w;
    end
  end

  // R3: a grant only goes to a LID meeting every eligibility condition
  p_grant_elig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> tbl_bind[pick] && frag_rdy_i[pick] && !lp_stat_i[tbl_lp[pick]][1]);

  // R4: the arbiter never reports a hit on a non-requesting entry
  p_pick_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> elig[pick]);

  // R7: egress valid trails the buffer read by one cycle
  p_vld_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> eg_vld_o);
  p_vld_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_o |=> !eg_vld_o);

  // R8: address only with a fragment's first word
  p_addr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eg_addr_vld_o |-> eg_first_q && eg_vld_o);

endmodule

// File: tb/eg_frag_sched_tb_top.sv
module eg_frag_sched_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int IW    = 3;
  localparam int LW    = 3;
  localparam int NLP   = 8;
  localparam int FL    = 4;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic              tbl_wr_en = 1'b0;
  logic [IW-1:0]     tbl_wr_idx = '0;
  logic              tbl_wr_bind = 1'b0;
  logic [LW-1:0]     tbl_wr_lp = '0;
  logic [NLP-1:0][1:0] stat = '0;
  logic [N-1:0]      en = '0;
  logic              rd_en;
  logic [IW-1:0]     rd_lid;
  logic [DW-1:0]     buf_data;
  logic              buf_sop, buf_eop, buf_err;
  logic              eg_vld, eg_sop, eg_eop, eg_err, eg_fend, eg_addr_vld;
  logic [DW-1:0]     eg_data;
  logic [LW-1:0]     eg_addr;

  eg_frag_sched #(.N_ENT(N), .LP_W(LW), .DW(DW), .FRAG_LEN(FL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_bind(tbl_wr_bind), .tbl_wr_lp(tbl_wr_lp),
    .lp_stat_i(stat), .frag_rdy_i(en),
    .rd_en_o(rd_en), .rd_lid_o(rd_lid),
    .buf_data_i(buf_data), .buf_sop_i(buf_sop), .buf_eop_i(buf_eop), .buf_err_i(buf_err),
    .eg_vld_o(eg_vld), .eg_data_o(eg_data), .eg_sop_o(eg_sop), .eg_eop_o(eg_eop),
    .eg_err_o(eg_err), .eg_fend_o(eg_fend), .eg_addr_vld_o(eg_addr_vld), .eg_addr_o(eg_addr)
  );

  // Bench fragment buffer: word = {lid, position in packet}
  int unsigned plen [N];
  logic        errf [N];
  logic [4:0]  bpos [N];

  always_comb begin
    buf_data = {rd_lid, bpos[rd_lid]};
    buf_sop  = (bpos[rd_lid] == 5'd0);
    buf_eop  = (int'(bpos[rd_lid]) + 1 == int'(plen[rd_lid]));
    buf_err  = errf[rd_lid] & buf_eop;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) bpos[i] <= 5'd0;
    end else if (rd_en) begin
      bpos[rd_lid] <= (int'(bpos[rd_lid]) + 1 == int'(plen[rd_lid])) ? 5'd0 : bpos[rd_lid] + 5'd1;
    end
  end

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Shadow of the table and the bench's own scheduling model
  logic          sh_bind [N];
  logic [LW-1:0] sh_lp   [N];
  int            rr_last = N - 1;
  int            epos [N];
  int            served [N];

  function automatic int exp_rr(input int last);
    for (int k = 1; k <= N; k++) begin
      int i;
      i = (last + k) % N;
      if (sh_bind[i] && en[i] && (stat[sh_lp[i]] == 2'b00 || stat[sh_lp[i]] == 2'b01)) return i;
    end
    return -1;
  endfunction

  // Monitor state
  bit  last_rd = 1'b0;
  int  exp_prev = -1;
  bit  in_frag = 1'b0;
  int  rd_cnt = 0;
  int  cur_lid = 0;
  int  x_lid, x_pos0, x_len, o_cnt = 0;
  bit  x_eop, x_addrv;
  logic [LW-1:0] x_lp;
  bit  pv = 1'b0;
  logic [LW-1:0] plp = '0;
  int  frag_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      // Output side, one cycle behind reads (R7)
      chk(eg_vld == last_rd, "R7 eg_vld follows read", int'(eg_vld), int'(last_rd));
      if (eg_vld) begin
        bit lastw;
        lastw = (o_cnt == x_len - 1);
        chk(eg_data == {IW'(x_lid), 5'(x_pos0 + o_cnt)}, "R7 data", int'(eg_data),
            int'({IW'(x_lid), 5'(x_pos0 + o_cnt)}));
        chk({eg_sop, eg_eop, eg_err} == {x_pos0 + o_cnt == 0, lastw && x_eop,
             lastw && x_eop && errf[x_lid]}, "R7 sop/eop/err",
            int'({eg_sop, eg_eop, eg_err}),
            int'({x_pos0 + o_cnt == 0, lastw && x_eop, lastw && x_eop && errf[x_lid]}));
        chk(eg_fend == lastw, "R6 fragment end marker", int'(eg_fend), int'(lastw));
        chk(eg_addr_vld == (o_cnt == 0 && x_addrv), "R8 address strobe",
            int'(eg_addr_vld), int'(o_cnt == 0 && x_addrv));
        if (eg_addr_vld) chk(eg_addr == x_lp, "R8 address value", int'(eg_addr), int'(x_lp));
        o_cnt++;
        if (eg_fend) begin o_cnt = 0; frag_cnt++; end
      end else begin
        chk(!eg_fend && !eg_addr_vld, "R7 quiet outputs when idle", int'({eg_fend, eg_addr_vld}), 0);
      end

      // Read side
      if (rd_en) begin
        if (!in_frag) begin
          chk(!last_rd, "R9 idle cycle before grant", int'(last_rd), 0);
          chk(exp_prev >= 0, "R3 grant only when eligible", int'(rd_lid), exp_prev);
          if (exp_prev >= 0) chk(int'(rd_lid) == exp_prev, "R4 round-robin pick", int'(rd_lid), exp_prev);
          in_frag = 1'b1;
          rd_cnt  = 0;
          cur_lid = int'(rd_lid);
          rr_last = cur_lid;
          served[cur_lid]++;
          x_lid  = cur_lid;
          x_pos0 = epos[cur_lid];
          x_len  = (int'(plen[cur_lid]) - x_pos0 < FL) ? int'(plen[cur_lid]) - x_pos0 : FL;
          x_eop  = (x_pos0 + x_len == int'(plen[cur_lid]));
          epos[cur_lid] = x_eop ? 0 : x_pos0 + x_len;
          x_lp    = sh_lp[cur_lid];
          x_addrv = !pv || (plp != x_lp);
          pv  = 1'b1;
          plp = x_lp;
        end else begin
          chk(int'(rd_lid) == cur_lid, "R5 read LID held", int'(rd_lid), cur_lid);
        end
        rd_cnt++;
      end else begin
        if (in_frag) begin
          chk(rd_cnt == x_len, "R6 words read per fragment", rd_cnt, x_len);
          in_frag = 1'b0;
        end else if (!last_rd) begin
          chk(exp_prev < 0, "R3 idle although eligible", 0, exp_prev);
        end
      end
    end
    exp_prev = exp_rr(rr_last);
    last_rd  = rst_n && rd_en;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tbl_write(input int idx, input bit b, input int lp);
    @(posedge clk); #1;
    tbl_wr_en = 1'b1; tbl_wr_idx = IW'(idx); tbl_wr_bind = b; tbl_wr_lp = LW'(lp);
    @(posedge clk); #1;
    tbl_wr_en = 1'b0;
    sh_bind[idx] = b;
    sh_lp[idx]   = LW'(lp);
  endtask

  task automatic wait_frags(input int n);
    int target;
    target = frag_cnt + n;
    while (frag_cnt < target) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      sh_bind[i] = 1'b0; sh_lp[i] = '0; epos[i] = 0; served[i] = 0;
      plen[i] = 5; errf[i] = 1'b0;
    end
    plen[0] = 6; plen[2] = 3; plen[3] = 4; plen[5] = 9; plen[6] = 1;
    plen[1] = 7; plen[4] = 2; errf[5] = 1'b1; errf[1] = 1'b1;
    stat = '0;
    tick(5);
    // R1: reset state
    chk(!rd_en && !eg_vld && !eg_fend && !eg_addr_vld, "R1 reset outputs",
        int'({rd_en, eg_vld, eg_fend, eg_addr_vld}), 0);
    rst_n = 1'b1;
    tick(1);
    chk(!rd_en && !eg_vld, "R1 outputs after reset release", int'({rd_en, eg_vld}), 0);

    // R2: table empty after reset -> nothing granted
    en = '1;
    for (int l = 0; l < NLP; l++) stat[l] = 2'b01;
    tick(20);
    chk(frag_cnt == 0, "R2 unbound entries never granted", frag_cnt, 0);

    // R3/R4: mixed binding and status codes
    en = '0;
    tbl_write(0, 1, 5);
    tbl_write(2, 1, 1);
    tbl_write(3, 1, 4);
    tbl_write(5, 1, 6);
    tbl_write(6, 1, 0);
    stat[4] = 2'b10;   // satisfied blocks LID 3
    stat[6] = 2'b11;   // reserved blocks LID 5
    stat[1] = 2'b00;   // starving
    en = '1;
    wait_frags(20);
    chk(served[3] == 0 && served[5] == 0, "R3 satisfied/reserved LP skipped",
        served[3] + served[5], 0);
    stat[4] = 2'b01;
    stat[6] = 2'b00;
    wait_frags(24);
    chk(served[3] > 0 && served[5] > 0, "R3 released LPs served", served[3] * served[5], 1);

    // R3: readiness flag gates LID 2
    begin
      int s2;
      en[2] = 1'b0;
      tick(3);
      s2 = served[2];
      wait_frags(15);
      chk(served[2] == s2, "R3 no grant without complete fragment", served[2], s2);
      en[2] = 1'b1;
    end

    // R2: unbinding removes LID 0
    begin
      int s0;
      tbl_write(0, 0, 5);
      tick(3);
      s0 = served[0];
      wait_frags(15);
      chk(served[0] == s0, "R2 unbound entry ignored", served[0], s0);
    end

    // R8: two LIDs sharing one LP, then a single LID
    en = '0;
    tick(12);
    for (int i = 0; i < N; i++) if (sh_bind[i]) tbl_write(i, 0, 0);
    tbl_write(1, 1, 2);
    tbl_write(4, 1, 2);
    stat = '0;
    en[1] = 1'b1; en[4] = 1'b1;
    wait_frags(12);
    en[4] = 1'b0;
    wait_frags(6);
    tbl_write(7, 1, 3);
    en[7] = 1'b1;
    wait_frags(8);

    // R5: status changes during a fragment do not cut it short
    begin
      int fc;
      en = '0;
      tick(12);
      en[1] = 1'b1;
      do @(negedge clk); while (!rd_en);
      fc = frag_cnt;
      @(posedge clk); #1;
      stat = {NLP{2'b10}};
      tick(20);
      chk(frag_cnt == fc + 1, "R5 fragment completes after status change", frag_cnt, fc + 1);
      chk(!rd_en, "R5 no new grant once satisfied", int'(rd_en), 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule